// File: doc/BRIEF.md
# Memory-Mapped Keyboard and Display Port Controller

This block sits between the memory interface of a 16-bit processor and two character devices: one that supplies typed characters and one that shows them. For every access it looks at the address register and decides whether the access goes to main memory or to a small window of device registers at the top of the address space. It raises the memory enable for ordinary addresses. It steers the read multiplexer to memory data, to a device register or to zero. On a store it raises the load enable of the device register that was addressed.

The block also holds the two device ready flags and the two character registers. The input flag is raised by a strobe from the keyboard side and dropped when the processor reads the input character. The output flag drops when the processor stores a character for display and rises again when the display reports that it is done. A polling loop on the processor reads a status word and tests its most significant bit before it moves a character.

Top module: `kbd_disp_mmio`

## Requirements
- R1: With `acc_en` high, an address below 0xFE00 raises `mem_en` and returns `mem_rdata` on `rdata` (select code 0). An address from 0xFE00 to 0xFFFF keeps `mem_en` low. With `acc_en` low, `mem_en` is low.
- R2: An I/O load steers `rd_sel` to the register at the exact address: 0xFE00 input status (code 1), 0xFE02 input character (code 2), 0xFE04 output status (code 3), 0xFE06 output character (code 4). I/O stores and idle cycles give code 5 and code 0 respectively.
- R3: An I/O store raises exactly one bit of `ld_en` for a mapped register: bit 0 for 0xFE00, bit 1 for 0xFE02, bit 2 for 0xFE04, bit 3 for 0xFE06. Loads, memory stores and unmapped stores keep `ld_en` at zero.
- R4: A status read carries the ready flag in bit 15, and bits 14 to 0 read as zero.
- R5: A cycle with `key_strobe` high latches `key_char` into the input character register, zero-extended, and the input flag is set after that edge. A strobe that arrives while the flag is already set overwrites the character and leaves the flag set.
- R6: A load of 0xFE02 returns the held character and clears the input flag at the next edge. If a strobe arrives in the same cycle, the flag ends up set and the new character is held.
- R7: A store to 0xFE06 latches `wdata[7:0]` onto `disp_char` and clears the output flag. `disp_go` is high for exactly the one cycle after that edge.
- R8: `disp_done` sets the output flag at the next edge. If it coincides with a store to 0xFE06, the store wins and the flag ends up clear.
- R9: After reset the input flag is 0, the output flag is 1, both character registers are zero and `disp_go` is low.
- R10: Loads of unmapped addresses in the window return zero with select code 5. Stores to the status registers, to 0xFE02 or to unmapped addresses leave every flag and character unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe for this cycle |
| acc_wr | input | 1 | 1 = store, 0 = load |
| addr | input | 16 | Address register contents |
| wdata | input | 16 | Store data |
| mem_rdata | input | 16 | Read data from main memory |
| rdata | output | 16 | Multiplexed read data |
| mem_en | output | 1 | Main memory enable |
| rd_sel | output | 3 | Read multiplexer select code |
| ld_en | output | 4 | Device register load enables |
| key_strobe | input | 1 | New character present on key_char |
| key_char | input | 8 | Character from the keyboard side |
| disp_done | input | 1 | Display has finished its character |
| disp_char | output | 8 | Character held for the display |
| disp_go | output | 1 | One-cycle pulse: new character to show |

## Verification
The assertions take it that `key_strobe` and `disp_done` are single-cycle, synchronous pulses. They also take it that `acc_en` is the only qualifier of an access, so `acc_wr`, `addr` and `wdata` may hold any value while it is low. The stimulus drives every input one time unit after a rising edge and holds it for one full cycle. The coincidence cases (a read with a strobe, a write with a done) are placed in the same driven cycle on purpose, so every flag update falls on one known edge.

// File: rtl/kbd_disp_pkg.sv
package kbd_disp_pkg;

    parameter int DATA_W = 16;
    parameter int CHAR_W = 8;
    parameter int NUM_DEV_REGS = 4;

    parameter logic [DATA_W-1:0] IO_BASE     = 16'hFE00;
    parameter logic [DATA_W-1:0] ADDR_KSTAT  = 16'hFE00;
    parameter logic [DATA_W-1:0] ADDR_KDATA  = 16'hFE02;
    parameter logic [DATA_W-1:0] ADDR_DSTAT  = 16'hFE04;
    parameter logic [DATA_W-1:0] ADDR_DDATA  = 16'hFE06;

    localparam int FLAG_BIT = DATA_W - 1;
    localparam int PAD_W    = DATA_W - CHAR_W;

    typedef enum logic [2:0] {
        SEL_MEM   = 3'd0,
        SEL_KSTAT = 3'd1,
        SEL_KDATA = 3'd2,
        SEL_DSTAT = 3'd3,
        SEL_DDATA = 3'd4,
        SEL_ZERO  = 3'd5
    } rsel_e;

    typedef struct packed {
        logic                    mem_en;
        rsel_e                   sel;
        logic [NUM_DEV_REGS-1:0] ld;
    } dec_t;

endpackage

// File: rtl/kbd_addr_decode.sv
module kbd_addr_decode
    import kbd_disp_pkg::*;
(
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [DATA_W-1:0] addr,
    output dec_t              dec
);

    logic       io_hit;
    logic       reg_hit;
    logic [1:0] reg_idx;

    assign io_hit = (addr >= IO_BASE);

    always_comb begin
        reg_hit = 1'b1;
        reg_idx = 2'd0;
        case (addr)
            ADDR_KSTAT: reg_idx = 2'd0;
            ADDR_KDATA: reg_idx = 2'd1;
            ADDR_DSTAT: reg_idx = 2'd2;
            ADDR_DDATA: reg_idx = 2'd3;
            default:    reg_hit = 1'b0;
        endcase
    end

    always_comb begin
        dec        = '0;
        dec.sel    = SEL_MEM;
        if (acc_en) begin
            if (!io_hit) begin
                dec.mem_en = 1'b1;
            end else if (acc_wr) begin
                dec.sel = SEL_ZERO;
                if (reg_hit) begin
                    dec.ld[reg_idx] = 1'b1;
                end
            end else begin
                dec.sel = reg_hit ? rsel_e'(3'(reg_idx) + 3'd1) : SEL_ZERO;
            end
        end
    end

endmodule

// File: rtl/kbd_in_port.sv
module kbd_in_port
    import kbd_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_strobe,
    input  logic [CHAR_W-1:0] key_char,
    input  logic              data_rd,
    output logic              rdy,
    output logic [CHAR_W-1:0] char_out
);

    typedef struct packed {
        logic              rdy;
        logic [CHAR_W-1:0] chr;
    } kst_t;

    kst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (data_rd) begin
            st_d.rdy = 1'b0;
        end
        if (key_strobe) begin
            st_d.rdy = 1'b1;
            st_d.chr = key_char;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy      = st_q.rdy;
    assign char_out = st_q.chr;

    AST_KRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        key_strobe |=> rdy); // R5
    AST_KRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !key_strobe) |=> !rdy); // R6
    AST_KCHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_strobe |=> $stable(char_out)); // R10

endmodule

// File: rtl/disp_out_port.sv
module disp_out_port
    import kbd_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              done,
    output logic              rdy,
    output logic [CHAR_W-1:0] char_out,
    output logic              go
);

    typedef struct packed {
        logic              rdy;
        logic              go;
        logic [CHAR_W-1:0] chr;
    } dst_t;

    dst_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.go = ld;
        if (done) begin
            st_d.rdy = 1'b1;
        end
        if (ld) begin
            st_d.rdy = 1'b0;
            st_d.chr = wchar;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.rdy <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy      = st_q.rdy;
    assign go       = st_q.go;
    assign char_out = st_q.chr;

    AST_DRDY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> !rdy); // R7
    AST_DGO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> go); // R7
    AST_DRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ld) |=> rdy); // R8
    AST_DCHAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(char_out)); // R10

endmodule

// File: rtl/kbd_disp_mmio.sv
module kbd_disp_mmio
    import kbd_disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_wr,
    input  logic [15:0]       addr,
    input  logic [15:0]       wdata,
    input  logic [15:0]       mem_rdata,
    output logic [15:0]       rdata,
    output logic              mem_en,
    output logic [2:0]        rd_sel,
    output logic [3:0]        ld_en,
    input  logic              key_strobe,
    input  logic [7:0]        key_char,
    input  logic              disp_done,
    output logic [7:0]        disp_char,
    output logic              disp_go
);

    dec_t              dec;
    logic              k_rdy;
    logic              d_rdy;
    logic [CHAR_W-1:0] k_char;
    logic              k_rd;

    kbd_addr_decode u_dec (
        .acc_en (acc_en),
        .acc_wr (acc_wr),
        .addr   (addr),
        .dec    (dec)
    );

    assign k_rd = (dec.sel == SEL_KDATA);

    kbd_in_port u_kin (
        .clk        (clk),
        .rst_n      (rst_n),
        .key_strobe (key_strobe),
        .key_char   (key_char),
        .data_rd    (k_rd),
        .rdy        (k_rdy),
        .char_out   (k_char)
    );

    disp_out_port u_dout (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (dec.ld[3]),
        .wchar    (wdata[CHAR_W-1:0]),
        .done     (disp_done),
        .rdy      (d_rdy),
        .char_out (disp_char),
        .go       (disp_go)
    );

    always_comb begin
        rdata = '0;
        case (dec.sel)
            SEL_MEM:   rdata = mem_rdata;
            SEL_KSTAT: rdata[FLAG_BIT] = k_rdy;
            SEL_KDATA: rdata = {{PAD_W{1'b0}}, k_char};
            SEL_DSTAT: rdata[FLAG_BIT] = d_rdy;
            SEL_DDATA: rdata = {{PAD_W{1'b0}}, disp_char};
            default:   rdata = '0;
        endcase
    end

    assign mem_en = dec.mem_en;
    assign rd_sel = dec.sel;
    assign ld_en  = dec.ld;

    AST_IO_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && addr >= IO_BASE) |-> !mem_en); // R1
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |-> (!mem_en && ld_en == '0)); // R1
    AST_LD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_en)); // R3
    AST_LD_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en != '0) |-> (acc_en && acc_wr && !mem_en)); // R3
    AST_STAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == SEL_KSTAT || rd_sel == SEL_DSTAT) |-> rdata[14:0] == '0); // R4

endmodule

// File: tb/test_kbd_disp_mmio.sv
`timescale 1ns/1ps
module test_kbd_disp_mmio;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] mem_rdata;
    logic [15:0] rdata;
    logic        mem_en;
    logic [2:0]  rd_sel;
    logic [3:0]  ld_en;
    logic        key_strobe = 1'b0;
    logic [7:0]  key_char = '0;
    logic        disp_done = 1'b0;
    logic [7:0]  disp_char;
    logic        disp_go;

    int n_chk = 0;
    int n_err = 0;

    typedef struct {
        logic [15:0] rd;
        logic        me;
        logic [2:0]  sel;
        logic [3:0]  ld;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    assign mem_rdata = addr ^ 16'h5A5A;

    kbd_disp_mmio i_kbd_disp_mmio (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (acc_wr),
        .addr       (addr),
        .wdata      (wdata),
        .mem_rdata  (mem_rdata),
        .rdata      (rdata),
        .mem_en     (mem_en),
        .rd_sel     (rd_sel),
        .ld_en      (ld_en),
        .key_strobe (key_strobe),
        .key_char   (key_char),
        .disp_done  (disp_done),
        .disp_char  (disp_char),
        .disp_go    (disp_go)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item for every driven access
    initial begin
        forever begin
            @(negedge clk);
            if (acc_en && sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " rdata"},  rdata, e.rd);
                chk({e.tag, " mem_en"}, 16'(mem_en), 16'(e.me));
                chk({e.tag, " rd_sel"}, 16'(rd_sel), 16'(e.sel));
                chk({e.tag, " ld_en"},  16'(ld_en), 16'(e.ld));
            end
        end
    end

    // driver: one access cycle with optional device-side pulses
    task automatic acc(input logic wr, input logic [15:0] a, input logic [15:0] wd,
                       input logic ks, input logic [7:0] kc, input logic dd,
                       input logic [15:0] e_rd, input logic [2:0] e_sel,
                       input logic [3:0] e_ld, input string tag);
        exp_t e;
        @(posedge clk); #1;
        acc_en = 1'b1; acc_wr = wr; addr = a; wdata = wd;
        key_strobe = ks; key_char = kc; disp_done = dd;
        e.rd = e_rd; e.me = (a < 16'hFE00); e.sel = e_sel; e.ld = e_ld; e.tag = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        acc_en = 1'b0; acc_wr = 1'b0; key_strobe = 1'b0; disp_done = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [15:0] e_rd,
                      input logic [2:0] e_sel, input string tag);
        acc(1'b0, a, 16'h0, 1'b0, 8'h0, 1'b0, e_rd, e_sel, 4'h0, tag);
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] wd,
                      input logic [3:0] e_ld, input string tag);
        logic [15:0] e_rd;
        e_rd = (a < 16'hFE00) ? (a ^ 16'h5A5A) : 16'h0;
        acc(1'b1, a, wd, 1'b0, 8'h0, 1'b0, e_rd,
            (a < 16'hFE00) ? 3'd0 : 3'd5, e_ld, tag);
    endtask

    task automatic pulse(input logic ks, input logic [7:0] kc, input logic dd);
        @(posedge clk); #1;
        key_strobe = ks; key_char = kc; disp_done = dd;
        @(posedge clk); #1;
        key_strobe = 1'b0; disp_done = 1'b0;
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset state, R4 flag position
        chk("R9 disp_go after reset", 16'(disp_go), 16'h0);
        rd(16'hFE00, 16'h0000, 3'd1, "R9 kbd status after reset");
        rd(16'hFE04, 16'h8000, 3'd3, "R9 R4 disp status after reset");
        rd(16'hFE02, 16'h0000, 3'd2, "R9 kbd char after reset");
        rd(16'hFE06, 16'h0000, 3'd4, "R9 disp char after reset");

        // R1 memory space
        rd(16'h0000, 16'h5A5A, 3'd0, "R1 mem read 0000");
        rd(16'h1234, 16'h1234 ^ 16'h5A5A, 3'd0, "R1 mem read 1234");
        rd(16'hFDFF, 16'hFDFF ^ 16'h5A5A, 3'd0, "R1 mem read top");
        wr(16'h2000, 16'hBEEF, 4'h0, "R1 R3 mem store");
        @(posedge clk); #1; addr = 16'h1000;
        @(negedge clk);
        chk("R1 idle mem_en", 16'(mem_en), 16'h0);
        chk("R2 idle rd_sel", 16'(rd_sel), 16'h0);

        // R5 arrival, R6 clear on read
        pulse(1'b1, 8'h41, 1'b0);
        rd(16'hFE00, 16'h8000, 3'd1, "R5 R4 kbd flag set");
        rd(16'hFE02, 16'h0041, 3'd2, "R5 kbd char latched");
        rd(16'hFE00, 16'h0000, 3'd1, "R6 kbd flag cleared by read");

        // R5 overwrite while set
        pulse(1'b1, 8'h42, 1'b0);
        pulse(1'b1, 8'h43, 1'b0);
        rd(16'hFE00, 16'h8000, 3'd1, "R5 flag stays set on overwrite");
        rd(16'hFE02, 16'h0043, 3'd2, "R5 overwritten char");

        // R6 read and arrival in same cycle
        pulse(1'b1, 8'h44, 1'b0);
        acc(1'b0, 16'hFE02, 16'h0, 1'b1, 8'h45, 1'b0, 16'h0044, 3'd2, 4'h0,
            "R6 read with arrival returns old char");
        rd(16'hFE00, 16'h8000, 3'd1, "R6 arrival wins flag");
        rd(16'hFE02, 16'h0045, 3'd2, "R6 new char held");

        // R7 display store
        wr(16'hFE06, 16'h1F7A, 4'h8, "R7 R3 disp store");
        chk("R7 disp_go pulse", 16'(disp_go), 16'h1);
        chk("R7 disp_char", 16'(disp_char), 16'h007A);
        @(posedge clk); #1;
        chk("R7 disp_go one cycle", 16'(disp_go), 16'h0);
        rd(16'hFE04, 16'h0000, 3'd3, "R7 disp flag cleared");
        rd(16'hFE06, 16'h007A, 3'd4, "R7 disp char readback");

        // R8 done sets, store wins over done
        pulse(1'b0, 8'h0, 1'b1);
        rd(16'hFE04, 16'h8000, 3'd3, "R8 done sets flag");
        acc(1'b1, 16'hFE06, 16'h0033, 1'b0, 8'h0, 1'b1, 16'h0, 3'd5, 4'h8,
            "R8 store with done");
        rd(16'hFE04, 16'h0000, 3'd3, "R8 store wins");
        pulse(1'b0, 8'h0, 1'b1);
        rd(16'hFE04, 16'h8000, 3'd3, "R8 flag set again");

        // R10 ignored stores, R3 enables
        pulse(1'b1, 8'h46, 1'b0);
        wr(16'hFE00, 16'h0000, 4'h1, "R3 R10 store kbd status");
        wr(16'hFE02, 16'h1234, 4'h2, "R3 R10 store kbd char");
        wr(16'hFE04, 16'h0000, 4'h4, "R3 R10 store disp status");
        wr(16'hFE08, 16'h00FF, 4'h0, "R3 R10 store unmapped");
        wr(16'hFFFF, 16'h00FF, 4'h0, "R3 R10 store top");
        rd(16'hFE00, 16'h8000, 3'd1, "R10 kbd flag unchanged");
        rd(16'hFE02, 16'h0046, 3'd2, "R10 kbd char unchanged");
        rd(16'hFE04, 16'h8000, 3'd3, "R10 disp flag unchanged");
        rd(16'hFE06, 16'h0033, 3'd4, "R10 disp char unchanged");
        chk("R10 disp_char port", 16'(disp_char), 16'h0033);
        rd(16'hFE01, 16'h0000, 3'd5, "R10 R2 unmapped read");
        rd(16'hFFFE, 16'h0000, 3'd5, "R10 R1 top unmapped read");

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule